// File: doc/BRIEF.md
# Banked Memory-Mapped Bus Selector

This block sits between a simple CPU-side bus and four 64-byte device banks that share one 8-bit address space. The top two address bits pick a bank. Separate read-enable and write-enable lines, gated by a master enable, become a read strobe or a write strobe for exactly one bank. The selected bank's read data comes back on a shared 8-bit return path. While no read is in progress, that path is forced quiet.

Bank 0 holds general RAM. Its top four bytes are two input bytes sampled from external pins and two output bytes that drive external pins. Bank 3 is a 64-byte store that holds a 32x16 one-bit-per-pixel image. Banks 1 and 2 are empty sockets. The bench and the notes cover only bus-side access; the display path that scans out pixels is not part of the block.

Read data is registered. A read presented at a rising edge returns its byte on `rdata_o`, with `drive_o` high, until the next edge.

Top module: `mbs_top`

## Requirements
- R1: After reset the following are all zero: `rdata_o`, `drive_o`, `err_o`, `gpo_o`, every RAM byte and every framebuffer byte.
- R2: Address bits [7:6] select the bank: 00 is RAM, 01 and 10 are empty, 11 is the framebuffer. Any access strobes at most one bank.
- R3: A write to RAM (bank 0, offsets 0x00–0x3B) stores the byte. A later read returns that byte on `rdata_o`, with `drive_o` high, in the cycle after the read edge.
- R4: When `en_i` is low, no bank is written, and in the next cycle `drive_o` is low and `rdata_o` is 0x00.
- R5: When `en_i`, `re_i` and `we_i` are all high, no access takes place, and in the next cycle `err_o` is high and `drive_o` is low.
- R6: A read of bank-0 offset 0x3C returns `gpi_i[7:0]`, and a read of offset 0x3D returns `gpi_i[15:8]`, both as sampled at the read edge. Writes to these two offsets change nothing.
- R7: Bank-0 offset 0x3E holds `gpo_o[7:0]` and offset 0x3F holds `gpo_o[15:8]`. Both are writable and read back. `gpo_o` changes only when one of these offsets is written.
- R8: Reads of banks 1 and 2 return 0x00 with `drive_o` high. Writes to those banks are discarded.
- R9: The framebuffer (addresses 0xC0–0xFF) is storage separate from RAM. Writing one offset in bank 3 leaves the same offset in bank 0 unchanged, and the reverse also holds.
- R10: `rdata_o` is 0x00 whenever `drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Master access enable |
| re_i | input | 1 | Read enable |
| we_i | input | 1 | Write enable |
| addr_i | input | 8 | Byte address; [7:6] bank, [5:0] offset |
| wdata_i | input | 8 | Write data |
| gpi_i | input | 16 | External input pins, two bytes |
| rdata_o | output | 8 | Registered read data |
| drive_o | output | 1 | High in the cycle after a valid read |
| err_o | output | 1 | High in the cycle after a read/write collision |
| gpo_o | output | 16 | External output pins, two bytes |

## Verification
Directed sequences come first. They write the same offset in bank 0 and bank 3 to expose aliasing between the two stores. They write and then read the input and output bytes to show that one group is read-only and the other is read/write. They repeat the same accesses with the master enable low and with both strobes high, which separates a suppressed access from a real one. Empty-bank writes are followed by reads of every populated bank, so a stray write shows up in the read data. A long pseudo-random run then mixes enables, strobes, addresses, data and pin values, and a behavioural model compares all outputs on every clock.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned NBANK   = 2 ** SEL_W;
  localparam int unsigned OFF_W   = ADDR_W - SEL_W;
  localparam int unsigned DEPTH   = 2 ** OFF_W;
  localparam int unsigned GPI_N   = 2;
  localparam int unsigned GPO_N   = 2;
  localparam int unsigned RAM_IDX = 0;
  localparam int unsigned FB_IDX  = NBANK - 1;

  typedef logic [SEL_W-1:0]  bank_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/mbs_decode.sv
module mbs_decode
  import mbs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              re_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NBANK-1:0]  rd_stb_o,
  output logic [NBANK-1:0]  wr_stb_o,
  output bank_t             bank_o,
  output off_t              off_o,
  output logic              collide_o
);
  logic rd_ok, wr_ok;

  assign bank_o    = addr_i[ADDR_W-1 -: SEL_W];
  assign off_o     = addr_i[OFF_W-1:0];
  assign rd_ok     = en_i & re_i & ~we_i;
  assign wr_ok     = en_i & we_i & ~re_i;
  assign collide_o = en_i & re_i & we_i;

  for (genvar b = 0; b < NBANK; b++) begin : g_sel
    logic hit;
    assign hit         = (bank_o == bank_t'(b));
    assign rd_stb_o[b] = rd_ok & hit;
    assign wr_stb_o[b] = wr_ok & hit;
  end

  p_one_bank_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_stb_o | wr_stb_o));
  p_no_stb_collide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && re_i && we_i) |-> ((rd_stb_o == '0) && (wr_stb_o == '0)));
  p_no_stb_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |-> ((rd_stb_o == '0) && (wr_stb_o == '0)));
endmodule

// File: rtl/mbs_ram_bank.sv
module mbs_ram_bank
  import mbs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_stb_i,
  input  logic                  wr_stb_i,
  input  off_t                  off_i,
  input  byte_t                 wdata_i,
  input  logic [GPI_N*DATA_W-1:0] gpi_i,
  output logic [GPO_N*DATA_W-1:0] gpo_o,
  output byte_t                 rdata_o
);
  localparam int unsigned GPI_BASE = DEPTH - GPI_N - GPO_N;
  localparam int unsigned GPO_BASE = DEPTH - GPO_N;
  localparam off_t GPI_BASE_O = off_t'(GPI_BASE);
  localparam off_t GPO_BASE_O = off_t'(GPO_BASE);

  byte_t mem_q [GPI_BASE];
  byte_t gpo_q [GPO_N];
  byte_t rd_val;

  always_comb begin
    rd_val = '0;
    if (off_i < GPI_BASE_O) begin
      rd_val = mem_q[off_i];
    end else begin
      for (int k = 0; k < GPI_N; k++)
        if (off_i == off_t'(GPI_BASE + k)) rd_val = gpi_i[k*DATA_W +: DATA_W];
      for (int k = 0; k < GPO_N; k++)
        if (off_i == off_t'(GPO_BASE + k)) rd_val = gpo_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < GPI_BASE; k++) mem_q[k] <= '0;
    end else if (wr_stb_i && off_i < GPI_BASE_O) begin
      mem_q[off_i] <= wdata_i;
    end
  end

  for (genvar k = 0; k < GPO_N; k++) begin : g_gpo
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        gpo_q[k] <= '0;
      else if (wr_stb_i && off_i == off_t'(GPO_BASE + k)) gpo_q[k] <= wdata_i;
    end
    assign gpo_o[k*DATA_W +: DATA_W] = gpo_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (rd_stb_i) rdata_o <= rd_val;
  end

  p_gpo_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_i && off_i >= GPO_BASE_O) |=> $stable(gpo_o));
endmodule

// File: rtl/mbs_fb_bank.sv
module mbs_fb_bank
  import mbs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  rd_stb_i,
  input  logic  wr_stb_i,
  input  off_t  off_i,
  input  byte_t wdata_i,
  output byte_t rdata_o
);
  // 32x16 pixels, 8 per byte
  byte_t pix_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) pix_q[k] <= '0;
    end else if (wr_stb_i) begin
      pix_q[off_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_o <= '0;
    else if (rd_stb_i) rdata_o <= pix_q[off_i];
  end
endmodule

// File: rtl/mbs_top.sv
module mbs_top
  import mbs_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    re_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [GPI_N*DATA_W-1:0] gpi_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    drive_o,
  output logic                    err_o,
  output logic [GPO_N*DATA_W-1:0] gpo_o
);
  logic [NBANK-1:0] rd_stb, wr_stb;
  bank_t            bank, bank_q;
  off_t             off;
  logic             collide;
  byte_t            bank_rd [NBANK];

  mbs_decode u_dec (
    .clk_i, .rst_ni, .en_i, .re_i, .we_i, .addr_i,
    .rd_stb_o (rd_stb), .wr_stb_o (wr_stb),
    .bank_o (bank), .off_o (off), .collide_o (collide)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b == RAM_IDX) begin : g_ram
      mbs_ram_bank u_ram (
        .clk_i, .rst_ni,
        .rd_stb_i (rd_stb[b]), .wr_stb_i (wr_stb[b]),
        .off_i (off), .wdata_i, .gpi_i, .gpo_o,
        .rdata_o (bank_rd[b])
      );
    end else if (b == FB_IDX) begin : g_fb
      mbs_fb_bank u_fb (
        .clk_i, .rst_ni,
        .rd_stb_i (rd_stb[b]), .wr_stb_i (wr_stb[b]),
        .off_i (off), .wdata_i,
        .rdata_o (bank_rd[b])
      );
    end else begin : g_empty
      assign bank_rd[b] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o <= 1'b0;
      err_o   <= 1'b0;
      bank_q  <= '0;
    end else begin
      drive_o <= |rd_stb;
      err_o   <= collide;
      if (|rd_stb) bank_q <= bank;
    end
  end

  assign rdata_o = drive_o ? bank_rd[bank_q] : '0;

  p_idle_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (!drive_o && !err_o && rdata_o == '0));
  p_collide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && re_i && we_i) |=> (err_o && !drive_o));
  p_empty_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && re_i && !we_i && bank != bank_t'(RAM_IDX) && bank != bank_t'(FB_IDX))
      |=> (drive_o && rdata_o == '0));
  p_read_drives_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && re_i && !we_i) |=> drive_o);
endmodule

// File: tb/tb_mbs_top.sv
module tb_mbs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 0, re = 0, we = 0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [15:0] gpi = '0;
  logic [7:0]  rdata;
  logic        drive, err;
  logic [15:0] gpo;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  byte unsigned m_ram [64];
  byte unsigned m_fb  [64];
  byte unsigned m_gpo [2];

  always #4 clk = ~clk;

  mbs_top dut (
    .clk_i (clk), .rst_ni (rst_n), .en_i (en), .re_i (re), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .gpi_i (gpi),
    .rdata_o (rdata), .drive_o (drive), .err_o (err), .gpo_o (gpo)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_rd(logic [7:0] a);
    int b = a[7:6];
    int o = a[5:0];
    if (b == 3) return m_fb[o];
    if (b != 0) return 0;
    if (o < 60) return m_ram[o];
    if (o == 60) return gpi[7:0];
    if (o == 61) return gpi[15:8];
    return m_gpo[o - 62];
  endfunction

  task automatic cyc(string tag, bit e, bit r, bit w, logic [7:0] a, logic [7:0] d);
    int  exp_rd;
    bit  exp_drv, exp_err;
    en = e; re = r; we = w; addr = a; wdata = d;
    exp_drv = e && r && !w;
    exp_err = e && r && w;
    exp_rd  = exp_drv ? model_rd(a) : 0;
    if (e && w && !r) begin
      if (a[7:6] == 2'd3) m_fb[a[5:0]] = d;
      else if (a[7:6] == 2'd0) begin
        if (a[5:0] < 60) m_ram[a[5:0]] = d;
        else if (a[5:0] >= 62) m_gpo[a[5:0] - 62] = d;
      end
    end
    @(posedge clk); #1;
    chk(tag, "rdata", rdata, exp_rd);
    chk(tag, "drive", drive, exp_drv);
    chk(tag, "err",   err,   exp_err);
    chk(tag, "gpo",   gpo,   {m_gpo[1], m_gpo[0]});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    foreach (m_ram[k]) m_ram[k] = 0;
    foreach (m_fb[k])  m_fb[k]  = 0;
    m_gpo[0] = 0; m_gpo[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rdata", rdata, 0); chk("R1", "drive", drive, 0);
    chk("R1", "err", err, 0);     chk("R1", "gpo", gpo, 0);
    rst_n = 1'b1;
    // R1: stores read zero after reset
    cyc("R1", 1, 1, 0, 8'h05, 0);
    cyc("R1", 1, 1, 0, 8'hC5, 0);
    // R3: RAM write/read
    cyc("R3", 1, 0, 1, 8'h00, 8'hA5);
    cyc("R3", 1, 0, 1, 8'h3B, 8'h5A);
    cyc("R3", 1, 1, 0, 8'h00, 0);
    cyc("R3", 1, 1, 0, 8'h3B, 0);
    // R9: no aliasing between bank 0 and bank 3
    cyc("R9", 1, 0, 1, 8'hC0, 8'h77);
    cyc("R9", 1, 1, 0, 8'h00, 0);
    cyc("R9", 1, 1, 0, 8'hC0, 0);
    cyc("R9", 1, 0, 1, 8'h10, 8'h33);
    cyc("R9", 1, 1, 0, 8'hD0, 0);
    // R6: GPI read-only
    gpi = 16'hBEEF;
    cyc("R6", 1, 1, 0, 8'h3C, 0);
    cyc("R6", 1, 1, 0, 8'h3D, 0);
    cyc("R6", 1, 0, 1, 8'h3C, 8'h11);
    gpi = 16'h1234;
    cyc("R6", 1, 1, 0, 8'h3C, 0);
    cyc("R6", 1, 1, 0, 8'h3D, 0);
    // R7: GPO
    cyc("R7", 1, 0, 1, 8'h3E, 8'hC3);
    cyc("R7", 1, 0, 1, 8'h3F, 8'h81);
    cyc("R7", 1, 1, 0, 8'h3E, 0);
    cyc("R7", 1, 1, 0, 8'h3F, 0);
    // R8: empty banks
    cyc("R8", 1, 0, 1, 8'h40, 8'hFF);
    cyc("R8", 1, 0, 1, 8'h80, 8'hFF);
    cyc("R8", 1, 1, 0, 8'h40, 0);
    cyc("R8", 1, 1, 0, 8'hBF, 0);
    cyc("R8", 1, 1, 0, 8'h00, 0);
    cyc("R8", 1, 1, 0, 8'hC0, 0);
    // R4: master enable off
    cyc("R4", 0, 0, 1, 8'h00, 8'h99);
    cyc("R4", 0, 1, 0, 8'h00, 0);
    cyc("R4", 0, 0, 1, 8'h3E, 8'h00);
    cyc("R4", 1, 1, 0, 8'h00, 0);
    // R5: collision
    cyc("R5", 1, 1, 1, 8'h00, 8'h42);
    cyc("R5", 1, 1, 1, 8'h3F, 8'h00);
    cyc("R5", 1, 1, 0, 8'h00, 0);
    cyc("R5", 1, 1, 0, 8'h3F, 0);
    // R10: idle bus after a read
    cyc("R10", 1, 0, 0, 8'h00, 0);
    // R2: mixed traffic
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[20:16] == 0) gpi = lfsr[31:16];
      cyc("R2", lfsr[3:0] != 0, lfsr[4], lfsr[5] | (lfsr[6] & lfsr[7]),
          lfsr[15:8], lfsr[27:20]);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule